// File: doc/BRIEF.md
# Early-Wakeup Micro-Op Issue Queue

This block is a small out-of-order issue queue. It accepts one micro-op per cycle. Each op carries a kind code, a destination tag and two source tags. The queue issues at most one op per cycle, and it wakes up consumers before their producers have finished executing. An issued op takes a fixed number of cycles to travel to its execution unit, and so does its producer. The scheduler can therefore release a consumer as soon as the producer's assumed execution time has passed since the producer's own issue. The operand is then ready exactly when the consumer reaches the unit.

Each op has a latency that is either fixed (single-cycle ALU, three-cycle multiply) or variable (memory load). A load's real latency is not known, so the queue charges every load a conservative, worst-case value: the second-level cache hit time. It never uses the shorter first-level time. A per-tag countdown timer starts when a producer issues and broadcasts the tag when the assumed time is over. Waiting entries capture the broadcast into their source ready bits.

Tags are assumed renamed: each tag has at most one producer in flight, and a consumer is allocated after its producer. A tag with no producer in flight reads as ready. The block also provides a delayed copy of the issue stream, which marks when each op arrives at its execution unit.

Top module: `uop_issue_sched`

## Requirements
- R1: After a synchronous active-low reset, `issue_valid`, `queue_full` and `exec_valid` are 0, and every tag reads as ready.
- R2: Kind code 0 (ALU) has latency LAT_ALU=1, code 1 (MUL) has LAT_MUL=3, and code 2 (LOAD) is always charged the worst-case LAT_LOAD=18. When nothing else competes, a consumer issues exactly that many cycles after its producer issues.
- R3: In a chain of ALU ops where each op consumes the previous op's destination, the ops issue on consecutive cycles.
- R4: No op issues while either of its source tags still has its producer's assumed latency outstanding.
- R5: An op whose source tags are ready when it is allocated can issue in the cycle after its allocation.
- R6: At most one op issues per cycle. Among the ready ops, the one allocated earliest wins, whatever slot it occupies.
- R7: `queue_full` is 1 exactly when all DEPTH=8 entries are occupied. An allocation presented while it is 1 is dropped, and that op never issues.
- R8: An issuing entry is freed at the end of its issue cycle. A full queue reports not full in the cycle after an issue.
- R9: Every issued op appears on `exec_valid` and `exec_tag` exactly DISPATCH_DIST=6 cycles after its issue cycle, carrying its destination tag.
- R10: A source tag that has no producer in flight counts as ready at allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate request this cycle |
| alloc_kind | input | 2 | 0 ALU, 1 MUL, 2 LOAD |
| alloc_dst | input | TAG_W | Destination tag |
| alloc_src_a | input | TAG_W | First source tag |
| alloc_src_b | input | TAG_W | Second source tag |
| queue_full | output | 1 | All entries occupied; allocation refused |
| issue_valid | output | 1 | An op issues this cycle |
| issue_tag | output | TAG_W | Destination tag of the issuing op |
| exec_valid | output | 1 | An issued op reaches its execution unit |
| exec_tag | output | TAG_W | Destination tag of the arriving op |

## Verification
Four properties are checked on every cycle:
- An issuing op never has a source tag still pending in the tag timers.
- A broadcast only wakes a tag that is pending.
- A refused allocation leaves the occupancy unchanged.
- An issue without an allocation lowers the occupancy by one.

Other behaviours can only be shown by the bench's scenarios, which compare issue cycles against hand-derived expected times. These are the exact latency of each kind, back-to-back ALU chains, age order winning over slot order, the dropped op under a full queue, and the arrival time at the execution unit.

// File: rtl/uop_sched_pkg.sv
// Package: shared kind encoding for the micro-op issue scheduler.
// Assumes the encoding is fixed at 2 bits; code 3 is treated as ALU.
package uop_sched_pkg;
    typedef enum logic [1:0] {
        KIND_ALU  = 2'd0,
        KIND_MUL  = 2'd1,
        KIND_LOAD = 2'd2,
        KIND_RSVD = 2'd3
    } uop_kind_e;
endpackage

// File: rtl/tag_timer.sv
// Module: tag_timer
// Tracks, per destination tag, whether a producer is in flight. Starts a
// countdown at producer issue and broadcasts the tag when the assumed
// latency has elapsed. Assumes one producer in flight per tag, and that
// every latency parameter is at least 1.
module tag_timer
    import uop_sched_pkg::*;
#(
    parameter int TAG_W    = 4,
    parameter int LAT_ALU  = 1,
    parameter int LAT_MUL  = 3,
    parameter int LAT_LOAD = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_v,
    input  logic [TAG_W-1:0]      set_tag,
    input  logic                  iss_v,
    input  logic [TAG_W-1:0]      iss_tag,
    input  uop_kind_e             iss_kind,
    input  logic [TAG_W-1:0]      qry_a,
    input  logic [TAG_W-1:0]      qry_b,
    output logic                  qry_rdy_a,
    output logic                  qry_rdy_b,
    output logic [(1<<TAG_W)-1:0] wake,
    output logic [(1<<TAG_W)-1:0] pend
);
    localparam int NTAGS   = 1 << TAG_W;
    localparam int LAT_MAX = (LAT_LOAD > LAT_MUL) ? ((LAT_LOAD > LAT_ALU) ? LAT_LOAD : LAT_ALU)
                                                  : ((LAT_MUL > LAT_ALU) ? LAT_MUL : LAT_ALU);
    localparam int CW      = $clog2(LAT_MAX + 1);

    logic [CW-1:0]    cnt_q [NTAGS];
    logic [NTAGS-1:0] pend_q;
    logic [NTAGS-1:0] set_mask;
    int               iss_lat;

    // Map an op kind to the latency the scheduler assumes for it.
    function automatic int lat_of(uop_kind_e k);
        case (k)
            KIND_MUL:  return LAT_MUL;
            KIND_LOAD: return LAT_LOAD;
            default:   return LAT_ALU;
        endcase
    endfunction

    // Latency of the op issuing this cycle, and the tag newly marked pending.
    always_comb begin
        iss_lat  = lat_of(iss_kind);
        set_mask = set_v ? (NTAGS'(1) << set_tag) : '0;
    end

    // Wake a tag on its last counted cycle, or at once for single-cycle ops.
    always_comb begin
        for (int t = 0; t < NTAGS; t++) begin
            wake[t] = (cnt_q[t] == CW'(1)) ||
                      (iss_v && (iss_tag == TAG_W'(t)) && (iss_lat == 1));
        end
    end

    // Count down running timers, start new ones, and update pending tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int t = 0; t < NTAGS; t++) cnt_q[t] <= '0;
        end else begin
            for (int t = 0; t < NTAGS; t++) begin
                if (cnt_q[t] != '0) cnt_q[t] <= cnt_q[t] - CW'(1);
                if (iss_v && (iss_tag == TAG_W'(t)) && (iss_lat > 1))
                    cnt_q[t] <= CW'(iss_lat - 1);
            end
            pend_q <= (pend_q & ~wake) | set_mask;
        end
    end

    // A source reads ready when no producer is pending or it wakes now.
    always_comb begin
        qry_rdy_a = !pend_q[qry_a] || wake[qry_a];
        qry_rdy_b = !pend_q[qry_b] || wake[qry_b];
        pend      = pend_q;
    end

    // R4: a broadcast only ever concerns a tag whose producer is pending.
    assert_wake_only_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wake & ~pend_q) == '0);
endmodule

// File: rtl/issue_queue.sv
// Module: issue_queue
// Holds up to DEPTH waiting ops with source ready bits. Captures wakeup
// broadcasts and grants the oldest ready entry through an age matrix.
// Assumes at most one allocation per cycle. Full ignores the same-cycle issue.
module issue_queue
    import uop_sched_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_v,
    input  uop_kind_e             alloc_kind,
    input  logic [TAG_W-1:0]      alloc_dst,
    input  logic [TAG_W-1:0]      alloc_sa,
    input  logic [TAG_W-1:0]      alloc_sb,
    input  logic                  alloc_rdy_a,
    input  logic                  alloc_rdy_b,
    input  logic [(1<<TAG_W)-1:0] wake,
    output logic                  full_o,
    output logic                  alloc_acc,
    output logic                  iss_v_o,
    output logic [TAG_W-1:0]      iss_dst_o,
    output uop_kind_e             iss_kind_o,
    output logic [TAG_W-1:0]      iss_sa_o,
    output logic [TAG_W-1:0]      iss_sb_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] valid_q, ra_q, rb_q, rdy, sel;
    logic [DEPTH-1:0] older_q [DEPTH];
    logic [TAG_W-1:0] dst_q [DEPTH];
    logic [TAG_W-1:0] sa_q  [DEPTH];
    logic [TAG_W-1:0] sb_q  [DEPTH];
    uop_kind_e        kind_q [DEPTH];
    logic [IW-1:0]    gidx, fidx;

    // Pick the oldest ready entry: ready with no older ready entry.
    always_comb begin
        rdy = valid_q & ra_q & rb_q;
        for (int i = 0; i < DEPTH; i++)
            sel[i] = rdy[i] && ((rdy & older_q[i]) == '0);
    end

    // Encode the grant and the lowest free slot.
    always_comb begin
        gidx = '0;
        fidx = '0;
        for (int i = 0; i < DEPTH; i++)
            if (sel[i]) gidx = IW'(i);
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!valid_q[i]) fidx = IW'(i);
    end

    // Queue-level outputs.
    always_comb begin
        full_o     = &valid_q;
        alloc_acc  = alloc_v && !full_o;
        iss_v_o    = |sel;
        iss_dst_o  = dst_q[gidx];
        iss_kind_o = kind_q[gidx];
        iss_sa_o   = sa_q[gidx];
        iss_sb_o   = sb_q[gidx];
    end

    // Capture wakeups, free the granted entry, write a new entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ra_q    <= '0;
            rb_q    <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                older_q[i] <= '0;
                dst_q[i]   <= '0;
                sa_q[i]    <= '0;
                sb_q[i]    <= '0;
                kind_q[i]  <= KIND_ALU;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (valid_q[i]) begin
                    ra_q[i] <= ra_q[i] | wake[sa_q[i]];
                    rb_q[i] <= rb_q[i] | wake[sb_q[i]];
                end
            end
            if (iss_v_o) valid_q[gidx] <= 1'b0;
            if (alloc_acc) begin
                for (int i = 0; i < DEPTH; i++) older_q[i][fidx] <= 1'b0;
                older_q[fidx] <= valid_q & ~sel;
                valid_q[fidx] <= 1'b1;
                dst_q[fidx]   <= alloc_dst;
                sa_q[fidx]    <= alloc_sa;
                sb_q[fidx]    <= alloc_sb;
                kind_q[fidx]  <= alloc_kind;
                ra_q[fidx]    <= alloc_rdy_a;
                rb_q[fidx]    <= alloc_rdy_b;
            end
        end
    end

    // R7: a request met by a full queue adds no entry.
    assert_full_refuses_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_v && full_o) |=>
        ($countones(valid_q) + int'($past(iss_v_o)) == $countones($past(valid_q))));

    // R8: an issue without an allocation frees exactly one entry.
    assert_issue_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_v_o && !alloc_acc) |=>
        ($countones(valid_q) + 1 == $countones($past(valid_q))));
endmodule

// File: rtl/dispatch_delay.sv
// Module: dispatch_delay
// Models the issue-to-execution-unit travel as DIST register stages.
// Assumes DIST >= 1.
module dispatch_delay #(
    parameter int DIST  = 6,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_v,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_v,
    output logic [TAG_W-1:0] out_tag
);
    logic             v_q [DIST];
    logic [TAG_W-1:0] t_q [DIST];

    // Shift the issued op one stage closer to its unit each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DIST; s++) begin
                v_q[s] <= 1'b0;
                t_q[s] <= '0;
            end
        end else begin
            v_q[0] <= in_v;
            t_q[0] <= in_tag;
            for (int s = 1; s < DIST; s++) begin
                v_q[s] <= v_q[s-1];
                t_q[s] <= t_q[s-1];
            end
        end
    end

    // Last stage is the arrival at the execution unit.
    always_comb begin
        out_v   = v_q[DIST-1];
        out_tag = t_q[DIST-1];
    end
endmodule

// File: rtl/uop_issue_sched.sv
// Module: uop_issue_sched
// Top of the early-wakeup issue scheduler. Combines the entry queue, the
// per-tag latency timers and the dispatch delay line. Assumes renamed tags
// (one producer in flight per tag) and loads charged the worst-case latency.
module uop_issue_sched
    import uop_sched_pkg::*;
#(
    parameter int DEPTH         = 8,
    parameter int TAG_W         = 4,
    parameter int LAT_ALU       = 1,
    parameter int LAT_MUL       = 3,
    parameter int LAT_LOAD      = 18,
    parameter int DISPATCH_DIST = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [1:0]       alloc_kind,
    input  logic [TAG_W-1:0] alloc_dst,
    input  logic [TAG_W-1:0] alloc_src_a,
    input  logic [TAG_W-1:0] alloc_src_b,
    output logic             queue_full,
    output logic             issue_valid,
    output logic [TAG_W-1:0] issue_tag,
    output logic             exec_valid,
    output logic [TAG_W-1:0] exec_tag
);
    localparam int NTAGS = 1 << TAG_W;

    logic             acc, rdy_a, rdy_b;
    logic [NTAGS-1:0] wake, tag_pend;
    uop_kind_e        iss_kind;
    logic [TAG_W-1:0] q_src_a, q_src_b;

    tag_timer #(
        .TAG_W(TAG_W), .LAT_ALU(LAT_ALU), .LAT_MUL(LAT_MUL), .LAT_LOAD(LAT_LOAD)
    ) u_timer (
        .clk(clk), .rst_n(rst_n),
        .set_v(acc), .set_tag(alloc_dst),
        .iss_v(issue_valid), .iss_tag(issue_tag), .iss_kind(iss_kind),
        .qry_a(alloc_src_a), .qry_b(alloc_src_b),
        .qry_rdy_a(rdy_a), .qry_rdy_b(rdy_b),
        .wake(wake), .pend(tag_pend)
    );

    issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_v(alloc_valid), .alloc_kind(uop_kind_e'(alloc_kind)),
        .alloc_dst(alloc_dst), .alloc_sa(alloc_src_a), .alloc_sb(alloc_src_b),
        .alloc_rdy_a(rdy_a), .alloc_rdy_b(rdy_b), .wake(wake),
        .full_o(queue_full), .alloc_acc(acc),
        .iss_v_o(issue_valid), .iss_dst_o(issue_tag), .iss_kind_o(iss_kind),
        .iss_sa_o(q_src_a), .iss_sb_o(q_src_b)
    );

    dispatch_delay #(.DIST(DISPATCH_DIST), .TAG_W(TAG_W)) u_dispatch (
        .clk(clk), .rst_n(rst_n),
        .in_v(issue_valid), .in_tag(issue_tag),
        .out_v(exec_valid), .out_tag(exec_tag)
    );

    // R4: the queue's ready bits never run ahead of the tag timers.
    assert_no_early_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (!tag_pend[q_src_a] && !tag_pend[q_src_b]));
endmodule

// File: tb/tb_uop_issue_sched.sv
`timescale 1ns/1ps
module tb_uop_issue_sched;
    localparam int DIST  = 6;
    localparam int NCYC  = 40;
    localparam int NVEC  = 27;
    localparam int NEVER = 255;

    // Fields: test, alloc cycle, kind, dst, src a, src b, expected issue cycle.
    localparam logic [35:0] VEC [NVEC] = '{
        36'h0_00_2_1_A_B_01, 36'h0_01_0_2_1_A_13, 36'h0_02_0_3_2_2_14,
        36'h0_03_1_4_C_D_04, 36'h0_04_0_5_4_E_07, 36'h0_05_0_6_5_3_15,
        36'h0_06_0_7_F_5_08, 36'h0_07_0_8_7_7_09,
        36'h1_00_2_9_A_B_01, 36'h1_01_0_1_9_9_13, 36'h1_02_0_2_1_1_14,
        36'h1_03_0_3_2_2_15, 36'h1_04_0_4_3_3_16,
        36'h2_00_1_1_A_B_01, 36'h2_01_0_2_1_A_04, 36'h2_02_0_3_1_B_05,
        36'h2_03_0_4_C_D_06,
        36'h3_00_2_1_A_B_01, 36'h3_01_0_2_1_1_13, 36'h3_02_0_3_1_1_14,
        36'h3_03_0_4_1_1_15, 36'h3_04_0_5_1_1_16, 36'h3_05_0_6_1_1_17,
        36'h3_06_0_7_1_1_18, 36'h3_07_0_8_1_1_19, 36'h3_08_0_9_1_1_1A,
        36'h3_09_0_0_C_D_FF
    };
    localparam string REQ [4] = '{"R2/R4/R5/R10", "R3", "R6", "R7/R8"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_valid = 1'b0;
    logic [1:0] alloc_kind = '0;
    logic [3:0] alloc_dst = '0, alloc_src_a = '0, alloc_src_b = '0;
    logic       queue_full, issue_valid, exec_valid;
    logic [3:0] issue_tag, exec_tag;

    int total = 0, bad = 0;
    int iss_cyc [16];
    int exe_cyc [16];
    logic full_hist [NCYC];

    uop_issue_sched dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
        .alloc_dst(alloc_dst), .alloc_src_a(alloc_src_a), .alloc_src_b(alloc_src_b),
        .queue_full(queue_full), .issue_valid(issue_valid), .issue_tag(issue_tag),
        .exec_valid(exec_valid), .exec_tag(exec_tag)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset, then drive one test's allocations while logging issue/exec cycles.
    task automatic run_test(input int tid);
        rst_n = 1'b0;
        alloc_valid = 1'b0;
        for (int t = 0; t < 16; t++) begin iss_cyc[t] = NEVER; exe_cyc[t] = NEVER; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NCYC; k++) begin
            if (k == 0) begin  // R1 reset state
                check(issue_valid == 1'b0, "R1 issue", int'(issue_valid), 0);
                check(queue_full == 1'b0, "R1 full", int'(queue_full), 0);
                check(exec_valid == 1'b0, "R1 exec", int'(exec_valid), 0);
            end
            full_hist[k] = queue_full;
            if (issue_valid) begin
                check(iss_cyc[issue_tag] == NEVER, "R6 duplicate issue", k, iss_cyc[issue_tag]);
                iss_cyc[issue_tag] = k;
            end
            if (exec_valid) exe_cyc[exec_tag] = k;
            alloc_valid = 1'b0;
            for (int v = 0; v < NVEC; v++) begin
                if (int'(VEC[v][35:32]) == tid && int'(VEC[v][31:24]) == k) begin
                    alloc_valid = 1'b1;
                    alloc_kind  = VEC[v][21:20];
                    alloc_dst   = VEC[v][19:16];
                    alloc_src_a = VEC[v][15:12];
                    alloc_src_b = VEC[v][11:8];
                end
            end
            @(negedge clk);
        end
        alloc_valid = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            if (int'(VEC[v][35:32]) == tid) begin
                int d, e;
                d = int'(VEC[v][19:16]);
                e = int'(VEC[v][7:0]);
                check(iss_cyc[d] == e, REQ[tid], iss_cyc[d], e);
                if (tid == 0)  // R9 arrival at the unit DIST cycles later
                    check(exe_cyc[d] == e + DIST, "R9", exe_cyc[d], e + DIST);
            end
        end
    endtask

    initial begin
        #(20000 * 5);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        run_test(0);
        run_test(1);
        run_test(2);
        run_test(3);
        // R7/R8: full only while all eight entries are held.
        check(full_hist[8] == 1'b0, "R7 full c8", int'(full_hist[8]), 0);
        check(full_hist[9] == 1'b1, "R7 full c9", int'(full_hist[9]), 1);
        check(full_hist[19] == 1'b1, "R7 full c19", int'(full_hist[19]), 1);
        check(full_hist[20] == 1'b0, "R8 full c20", int'(full_hist[20]), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule